// File: doc/BRIEF.md
# Interval Timer with Watchdog Mode

This block is a free-running interval timer that can be turned into a watchdog. A prescaler divides the block clock by a power of two. One of four taps of that prescaler is chosen, and each rising edge of the chosen tap advances a small up-counter by one. When the counter wraps from its top value to zero, that event is an overflow. An overflow does three things. It sets a sticky interrupt request flag. It emits a one-cycle wait-release pulse that standby sequencing uses to end an oscillator-settle delay. When watchdog mode is armed, it emits a one-cycle internal reset instead of setting the flag.

Software reaches the block through a single-cycle write strobe and a combinational read port. A write to the mode register sets the tap code. In the same write, bit 0 set to 1 restarts the counter, the prescaler and the interrupt flag. The watchdog arm bit can only be set by software. Only the external reset clears it; the block's own internal reset leaves it set. The running count can be read at any time, so firmware can measure short intervals or service the watchdog by clearing the counter.

Top module: `interval_guard_timer`

## Requirements
- R1: After external reset (rst_n low at a clock edge) the count reads 0, the tap code reads 0, the watchdog arm bit reads 0, and irq_flag, wait_release and wdt_reset are all low.
- R2: Tap codes 0, 1, 2 and 3 select count clocks of clk/2^TAP0_EXP, clk/2^TAP1_EXP, clk/2^TAP2_EXP and clk/2^TAP3_EXP respectively. Consecutive overflows are then 2^(TAPn_EXP+CNT_W) clock cycles apart.
- R3: Tap codes 4 to 7 are reserved and behave exactly like code 3, the slowest tap.
- R4: After a clear write with tap exponent T, the counter advances exactly once per 2^T cycles. The first advance takes effect 2^(T-1)+1 cycles after the write edge, and the first overflow pulse appears 2^(T-1)+(2^CNT_W-1)*2^T+1 cycles after that edge.
- R5: With rd_sel = 0, rd_data shows the current count, zero-extended.
- R6: A write with wr_sel = 0 stores wr_data[3:1] as the tap code. If wr_data[0] = 1, the same write zeroes the count, the prescaler and irq_flag, and this clear takes priority over a simultaneous overflow. If wr_data[0] = 0, the count is left running. With rd_sel = 1, rd_data reads {tap code, 0}; the clear bit always reads 0.
- R7: While the watchdog is not armed, an overflow sets irq_flag. The flag then stays set until a clear write or an external reset.
- R8: Every overflow produces a wait_release pulse exactly one cycle wide, in both modes.
- R9: A write with wr_sel = 1 and wr_data[0] = 1 arms the watchdog. rd_sel = 2 then reads 1. Each later overflow produces a wdt_reset pulse one cycle wide, in the same cycle as wait_release, and irq_flag is not set.
- R10: Writing 0 to the watchdog arm bit has no effect. The block's own wdt_reset does not disarm it either. Only rst_n does.
- R11: Clear writes issued more often than once per overflow period prevent any wdt_reset and any wait_release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (main clock) |
| rst_n | input | 1 | External synchronous reset, active low |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_sel | input | 1 | Write target: 0 mode register, 1 watchdog arm register |
| wr_data | input | 4 | Write data |
| rd_sel | input | 2 | Read source: 0 count, 1 mode, 2 watchdog arm, 3 zero |
| rd_data | output | RD_W | Read data (RD_W = max(CNT_W, 4)) |
| irq_flag | output | 1 | Sticky interrupt request flag |
| wait_release | output | 1 | One-cycle pulse on every overflow |
| wdt_reset | output | 1 | One-cycle internal reset pulse in watchdog mode |

## Verification
Some properties are checked by assertions on every cycle. The tick and all three output pulses must be single-cycle events. The arm bit must never fall while rst_n is high. The interrupt flag may rise only out of a tick while the watchdog is disarmed. A clear write must leave a zero count and a dropped flag. The count may change only on a tick or a clear. Other behaviour depends on exact cycle counts, and only the bench's scenarios can show it: the overflow period of every tap code including the reserved ones, the delay from a clear to the first overflow, the readback values, that a write of 0 to the arm bit does nothing, and that periodic clearing starves the watchdog.

// File: rtl/iwt_pkg.sv
// Package: shared encodings for the interval/guard timer.
// Assumes: four prescaler taps, tap code is 3 bits with codes 4..7 reserved.
package iwt_pkg;

    typedef logic [2:0] tap_code_t;
    typedef logic [1:0] tap_idx_t;

    typedef enum logic [1:0] {
        RD_COUNT = 2'd0,
        RD_MODE  = 2'd1,
        RD_GUARD = 2'd2,
        RD_NONE  = 2'd3
    } rd_src_e;

    localparam logic WSEL_MODE  = 1'b0;
    localparam logic WSEL_GUARD = 1'b1;

    // Maps a stored tap code to a tap index; reserved codes fall to the slowest tap.
    function automatic tap_idx_t code_to_idx(input tap_code_t code);
        if (code[2]) begin
            return 2'd3;
        end
        return code[1:0];
    endfunction

endpackage

// File: rtl/iwt_prescaler.sv
// Module: iwt_prescaler
// Free-running power-of-two divider with four taps. The selected tap is
// passed through a rising-edge detector so that one tick is produced per
// tap period. Assumes TAP0_EXP..TAP3_EXP ascending and all at least 1.
module iwt_prescaler #(
    parameter int TAP0_EXP = 5,
    parameter int TAP1_EXP = 7,
    parameter int TAP2_EXP = 9,
    parameter int TAP3_EXP = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           restart,
    input  iwt_pkg::tap_idx_t tap_idx,
    output logic           tick
);
    localparam int DIV_W = TAP3_EXP;
    localparam int TAPS [4] = '{TAP0_EXP, TAP1_EXP, TAP2_EXP, TAP3_EXP};

    logic [DIV_W-1:0] div_q;
    logic [3:0]       tap_bits;
    logic             tap_now;
    logic             tap_q;

    // Pick out each tap bit of the divider.
    generate
        for (genvar k = 0; k < 4; k++) begin : g_tap
            assign tap_bits[k] = div_q[TAPS[k]-1];
        end
    endgenerate

    // Select the active tap and detect its rising edge.
    always_comb begin
        tap_now = tap_bits[tap_idx];
        tick    = tap_now & ~tap_q;
    end

    // Advance the divider; restart puts it and the edge detector back to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            div_q <= '0;
            tap_q <= 1'b0;
        end else begin
            div_q <= div_q + 1'b1;
            tap_q <= tap_now;
        end
    end

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R4

endmodule

// File: rtl/iwt_counter.sv
// Module: iwt_counter
// Up-counter advanced by the prescaler tick. It flags the wrap from the top
// value as an overflow, registers a one-cycle pulse for it and keeps the
// sticky interrupt flag. Assumes clear takes priority over a coincident tick.
module iwt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic             guard_on,
    output logic [CNT_W-1:0] count,
    output logic             ovf,
    output logic             ovf_pulse,
    output logic             irq_flag
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    // Overflow is the tick that wraps the top value, unless a clear is under way.
    always_comb begin
        ovf = tick && (count == CNT_TOP) && !clear;
    end

    // Count ticks; a clear zeroes the count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
        end else if (tick) begin
            count <= count + 1'b1;
        end
    end

    // Register the overflow pulse that serves as the wait release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_pulse <= 1'b0;
        end else begin
            ovf_pulse <= ovf;
        end
    end

    // Keep the sticky interrupt flag; it is only set while the watchdog is off.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            irq_flag <= 1'b0;
        end else if (ovf && !guard_on) begin
            irq_flag <= 1'b1;
        end
    end

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !tick) |=> $stable(count)); // R4
    AST_RELEASE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |=> !ovf_pulse); // R8
    AST_IRQ_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> $past(tick)); // R7

endmodule

// File: rtl/iwt_regs.sv
// Module: iwt_regs
// Software-visible state: the tap code, the one-way watchdog arm bit, the
// self-clearing clear strobe and the read multiplexer. Assumes RD_W >= 4 and
// RD_W >= CNT_W.
module iwt_regs #(
    parameter int CNT_W = 8,
    parameter int RD_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [3:0]        wr_data,
    input  logic [1:0]        rd_sel,
    input  logic [CNT_W-1:0]  count,
    output iwt_pkg::tap_idx_t tap_idx,
    output logic              clear,
    output logic              guard_on,
    output logic [RD_W-1:0]   rd_data
);
    import iwt_pkg::*;

    tap_code_t tap_code;
    logic      mode_wr;
    logic      guard_wr;

    // Decode the write strobe; the clear bit is never stored.
    always_comb begin
        mode_wr  = wr_en && (wr_sel == WSEL_MODE);
        guard_wr = wr_en && (wr_sel == WSEL_GUARD);
        clear    = mode_wr && wr_data[0];
        tap_idx  = code_to_idx(tap_code);
    end

    // Hold the tap code written through the mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap_code <= '0;
        end else if (mode_wr) begin
            tap_code <= wr_data[3:1];
        end
    end

    // The arm bit can only be set; only the external reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            guard_on <= 1'b0;
        end else if (guard_wr && wr_data[0]) begin
            guard_on <= 1'b1;
        end
    end

    // Return the selected source, zero-extended.
    always_comb begin
        unique case (rd_src_e'(rd_sel))
            RD_COUNT: rd_data = RD_W'(count);
            RD_MODE:  rd_data = RD_W'({tap_code, 1'b0});
            RD_GUARD: rd_data = RD_W'(guard_on);
            default:  rd_data = '0;
        endcase
    end

    AST_GUARD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        guard_on |=> guard_on); // R10

endmodule

// File: rtl/interval_guard_timer.sv
// Module: interval_guard_timer (top)
// Interval timer with a one-way watchdog mode. Ties together the prescaler,
// the counter and the register file, and registers the internal reset pulse.
// Assumes rst_n is the external reset; wdt_reset is consumed outside the block.
module interval_guard_timer #(
    parameter int CNT_W    = 8,
    parameter int TAP0_EXP = 5,
    parameter int TAP1_EXP = 7,
    parameter int TAP2_EXP = 9,
    parameter int TAP3_EXP = 12,
    localparam int RD_W    = (CNT_W < 4) ? 4 : CNT_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            wr_sel,
    input  logic [3:0]      wr_data,
    input  logic [1:0]      rd_sel,
    output logic [RD_W-1:0] rd_data,
    output logic            irq_flag,
    output logic            wait_release,
    output logic            wdt_reset
);
    iwt_pkg::tap_idx_t tap_idx;
    logic              clear;
    logic              guard_on;
    logic              tick;
    logic              ovf;
    logic [CNT_W-1:0]  count;

    iwt_regs #(.CNT_W(CNT_W), .RD_W(RD_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .count(count),
        .tap_idx(tap_idx), .clear(clear), .guard_on(guard_on),
        .rd_data(rd_data)
    );

    iwt_prescaler #(
        .TAP0_EXP(TAP0_EXP), .TAP1_EXP(TAP1_EXP),
        .TAP2_EXP(TAP2_EXP), .TAP3_EXP(TAP3_EXP)
    ) u_pre (
        .clk(clk), .rst_n(rst_n), .restart(clear),
        .tap_idx(tap_idx), .tick(tick)
    );

    iwt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clear(clear), .tick(tick),
        .guard_on(guard_on), .count(count), .ovf(ovf),
        .ovf_pulse(wait_release), .irq_flag(irq_flag)
    );

    // Register the one-cycle internal reset raised by an overflow in watchdog mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdt_reset <= 1'b0;
        end else begin
            wdt_reset <= ovf && guard_on;
        end
    end

    AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_reset |=> !wdt_reset); // R9
    AST_RST_WITH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_reset |-> wait_release); // R8
    AST_NO_IRQ_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> !$past(guard_on)); // R9
    AST_CLEAR_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && wr_data[0]) |=> (count == '0) && !irq_flag); // R6

endmodule

// File: tb/sim_interval_guard_timer.sv
// Bench: sweeps all eight tap codes on a small configuration and exercises
// the interrupt, watchdog and clear behaviour with arithmetic expectations.
module sim_interval_guard_timer;
    localparam int CW = 4;
    localparam int TE [4] = '{1, 2, 3, 5};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [3:0] wr_data = 4'd0;
    logic [1:0] rd_sel = 2'd0;
    logic [3:0] rd_data;
    logic       irq_flag, wait_release, wdt_reset;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    interval_guard_timer #(.CNT_W(CW), .TAP0_EXP(1), .TAP1_EXP(2),
                           .TAP2_EXP(3), .TAP3_EXP(5)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .irq_flag(irq_flag), .wait_release(wait_release), .wdt_reset(wdt_reset)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the write edge.
    task automatic wr(input logic sel, input logic [3:0] d);
        wr_sel = sel; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output int v);
        rd_sel = s; #1; v = int'(rd_data);
    endtask

    // Counts negedges until wait_release is seen high (limit guards a hang).
    task automatic wait_ovf(output int k);
        k = 0;
        while (!wait_release && k < 5000) begin
            @(negedge clk); k++;
        end
    endtask

    initial begin
        int v, k, t, exp_first, npulse, nrel;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd(2'd0, v); chk(v == 0, "R1 count", v, 0);
        rd(2'd1, v); chk(v == 0, "R1 mode", v, 0);
        rd(2'd2, v); chk(v == 0, "R1 guard", v, 0);
        chk({irq_flag, wait_release, wdt_reset} == 3'b000, "R1 outputs",
            int'({irq_flag, wait_release, wdt_reset}), 0);

        // R2, R3, R4: sweep every tap code
        for (int code = 0; code < 8; code++) begin
            t = (code < 4) ? TE[code] : TE[3];
            wr(1'b0, {code[2:0], 1'b1});
            rd(2'd1, v); chk(v == code * 2, "R6 mode readback", v, code * 2);
            exp_first = (1 << (t - 1)) + ((1 << CW) - 1) * (1 << t) + 1;
            wait_ovf(k);
            chk(k == exp_first, code < 4 ? "R4 first overflow" : "R3 first overflow",
                k, exp_first);
            @(negedge clk);
            chk(!wait_release, "R8 pulse width", int'(wait_release), 0);
            wait_ovf(k);
            chk(k + 1 == (1 << (t + CW)), code < 4 ? "R2 period" : "R3 period",
                k + 1, 1 << (t + CW));
        end
        // R7: flag sticky, then cleared by a clear write
        repeat (3) @(negedge clk);
        chk(irq_flag, "R7 flag sticky", int'(irq_flag), 1);

        // R5, R6: readback and write without clear
        wr(1'b0, 4'b0111);
        chk(!irq_flag, "R6 clear drops flag", int'(irq_flag), 0);
        repeat (119) @(negedge clk);
        rd(2'd0, v); chk(v == 4, "R5 count readback", v, 4);
        wr(1'b0, 4'b0110);
        rd(2'd0, v); chk(v == 4, "R6 no-clear write keeps count", v, 4);
        rd(2'd1, v); chk(v == 6, "R6 clear bit reads 0", v, 6);

        // R10: writing 0 to the arm bit leaves it off
        wr(1'b1, 4'b0000);
        rd(2'd2, v); chk(v == 0, "R10 zero write", v, 0);
        // R9: arm, then a zero write has no effect
        wr(1'b1, 4'b0001);
        rd(2'd2, v); chk(v == 1, "R9 armed", v, 1);
        wr(1'b1, 4'b0000);
        rd(2'd2, v); chk(v == 1, "R10 cannot disarm", v, 1);
        wr(1'b0, 4'b0001);
        wait_ovf(k);
        chk(k == 32, "R9 reset timing", k, 32);
        chk(wdt_reset && !irq_flag, "R9 reset not irq",
            int'({wdt_reset, irq_flag}), 2);
        @(negedge clk);
        chk(!wdt_reset, "R9 reset width", int'(wdt_reset), 0);
        rd(2'd2, v); chk(v == 1, "R10 survives own reset", v, 1);

        // R11: periodic clears starve the watchdog
        npulse = 0; nrel = 0;
        for (int i = 0; i < 15; i++) begin
            wr(1'b0, 4'b0001);
            for (int j = 0; j < 20; j++) begin
                npulse += int'(wdt_reset); nrel += int'(wait_release);
                @(negedge clk);
            end
        end
        chk(npulse == 0 && nrel == 0, "R11 no reset", npulse + nrel, 0);

        // R10, R1: only the external reset disarms
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        rd(2'd2, v); chk(v == 0, "R10 external reset disarms", v, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog timeout actual=0 expected=1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule